// File: doc/BRIEF.md
# Timestamp Snapshot Activity Test Monitor

This block is a test and debug aid for a time-synchronisation unit. Each Ethernet channel has a receive and a transmit snapshot-taken strobe, and each CAN controller has one snapshot strobe. A 32-bit configuration word picks one source for the receive test output and one for the transmit test output. Each picked source is decoded from a sparse 4-bit code. Ethernet channels sit at the low codes. The CAN controllers start at the half-way code. Every unused code selects nothing.

While the test-mode bit of the configuration word is set, each strobe from a picked source becomes a pulse of exactly eight clock cycles on the matching output. A new strobe during a pulse restarts the count. When test mode is cleared, or when the select field of a direction is rewritten with a new value, that output drops at once. The configuration word is written and read through a plain single-register port.

Top module: `snap_test_mon`

## Requirements
- R1: After reset the configuration word reads 0x0000_0000 and both pulse outputs are low. This selects Ethernet channel 0 for both directions, with test mode off.
- R2: The configuration word has these fields: bit 0 is test mode, bit 1 is an auxiliary enable, bits 7:4 are the transmit select and bits 11:8 are the receive select. A write stores these fields. All other bits read as zero.
- R3: Select codes 0 to 4 pick Ethernet channels 0 to 4 (receive strobes for the receive output, transmit strobes for the transmit output).
- R4: Select code 8 picks CAN controller 0 and code 9 picks CAN controller 1, for either direction.
- R5: Select codes 5, 6, 7 and 10 to 15 pick no source, so no strobe causes a pulse.
- R6: While test mode (bit 0) is clear, both pulse outputs stay low whatever the strobes do.
- R7: A strobe from the picked source, sampled at a clock edge, drives the output high from that edge for exactly eight cycles.
- R8: A strobe that arrives while a pulse is active restarts the eight-cycle count from its own edge.
- R9: A write that clears test mode, or that changes a direction's select code, drives that direction's output low at the write's edge. A strobe sampled at that same edge is discarded. A write that leaves a select code unchanged does not cut that direction's pulse.
- R10: The auxiliary enable bit is stored and read back but has no effect on either output.
- R11: A write takes effect at the clock edge that samples it. A strobe at that edge is judged against the settings in force before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Write strobe for the configuration word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Current configuration word |
| eth_rx_evt | input | NUM_ETH | Per-channel receive snapshot strobes |
| eth_tx_evt | input | NUM_ETH | Per-channel transmit snapshot strobes |
| can_evt | input | NUM_CAN | Per-controller CAN snapshot strobes |
| rx_snap_pulse | output | 1 | Stretched activity of the receive source |
| tx_snap_pulse | output | 1 | Stretched activity of the transmit source |

## Verification
The assertions assume every strobe is a single-cycle level that is already synchronous to clk and stable around each edge. They also assume the configuration word changes only through the write port. The bench drives all strobes and writes at the falling edge and holds each strobe for one cycle, so every input is settled when the design samples it. Writes fall on any cycle, including cycles that carry strobes, so the same-edge ordering of R9 and R11 is exercised rather than avoided.

// File: rtl/snap_mon_pkg.sv
package snap_mon_pkg;
  localparam int REG_W   = 32;
  localparam int SEL_W   = 4;
  localparam int TM_BIT  = 0;
  localparam int AUX_BIT = 1;
  localparam int TX_LSB  = 4;
  localparam int RX_LSB  = 8;
  localparam logic [REG_W-1:0] RD_MASK = 32'h0000_0FF3;

  typedef struct packed {
    logic [SEL_W-1:0] rx_sel;
    logic [SEL_W-1:0] tx_sel;
    logic             aux;
    logic             tm;
  } cfg_t;

  function automatic cfg_t cfg_unpack(input logic [REG_W-1:0] w);
    cfg_t c;
    c.rx_sel = w[RX_LSB +: SEL_W];
    c.tx_sel = w[TX_LSB +: SEL_W];
    c.aux    = w[AUX_BIT];
    c.tm     = w[TM_BIT];
    return c;
  endfunction

  function automatic logic [REG_W-1:0] cfg_pack(input cfg_t c);
    logic [REG_W-1:0] w;
    w = '0;
    w[RX_LSB +: SEL_W] = c.rx_sel;
    w[TX_LSB +: SEL_W] = c.tx_sel;
    w[AUX_BIT]         = c.aux;
    w[TM_BIT]          = c.tm;
    return w;
  endfunction
endpackage

// File: rtl/snap_cfg_reg.sv
module snap_cfg_reg
  import snap_mon_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  output cfg_t             cfg_q,
  output logic [1:0]       flush
);
  cfg_t nxt;
  assign nxt = cfg_unpack(wdata);

  // index 0 = receive, 1 = transmit
  assign flush[0] = !cfg_q.tm || (wr_en && (!nxt.tm || nxt.rx_sel != cfg_q.rx_sel));
  assign flush[1] = !cfg_q.tm || (wr_en && (!nxt.tm || nxt.tx_sel != cfg_q.tx_sel));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cfg_q <= '0;
    else if (wr_en) cfg_q <= nxt;
  end
endmodule

// File: rtl/snap_src_sel.sv
module snap_src_sel
  import snap_mon_pkg::*;
#(
  parameter int NUM_ETH = 5,
  parameter int NUM_CAN = 2
) (
  input  logic [SEL_W-1:0]   sel,
  input  logic [NUM_ETH-1:0] eth_evt,
  input  logic [NUM_CAN-1:0] can_evt,
  output logic               hit
);
  localparam int CAN_BASE = 2 ** (SEL_W - 1);

  always_comb begin
    hit = 1'b0;
    for (int i = 0; i < NUM_ETH; i++)
      if (sel == SEL_W'(i)) hit = eth_evt[i];
    for (int j = 0; j < NUM_CAN; j++)
      if (sel == SEL_W'(CAN_BASE + j)) hit = can_evt[j];
  end
endmodule

// File: rtl/snap_pulse_stretch.sv
module snap_pulse_stretch #(
  parameter int PULSE_LEN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic flush,
  input  logic trig,
  output logic pulse
);
  localparam int CNT_W = $clog2(PULSE_LEN + 1);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (flush)      cnt <= '0;
    else if (trig)       cnt <= CNT_W'(PULSE_LEN);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign pulse = (cnt != '0);
endmodule

// File: rtl/snap_test_mon.sv
module snap_test_mon
  import snap_mon_pkg::*;
#(
  parameter int NUM_ETH   = 5,
  parameter int NUM_CAN   = 2,
  parameter int PULSE_LEN = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr_en,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  input  logic [NUM_ETH-1:0] eth_rx_evt,
  input  logic [NUM_ETH-1:0] eth_tx_evt,
  input  logic [NUM_CAN-1:0] can_evt,
  output logic               rx_snap_pulse,
  output logic               tx_snap_pulse
);
  cfg_t             cfg_q;
  logic [1:0]       flush_d;
  logic [1:0]       hit_d;
  logic [1:0]       pulse_d;
  logic [SEL_W-1:0] sel_d [2];
  logic [NUM_ETH-1:0] eth_d [2];

  snap_cfg_reg u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (reg_wr_en),
    .wdata (reg_wdata),
    .cfg_q (cfg_q),
    .flush (flush_d)
  );

  assign sel_d[0] = cfg_q.rx_sel;
  assign sel_d[1] = cfg_q.tx_sel;
  assign eth_d[0] = eth_rx_evt;
  assign eth_d[1] = eth_tx_evt;

  for (genvar d = 0; d < 2; d++) begin : g_dir
    snap_src_sel #(.NUM_ETH(NUM_ETH), .NUM_CAN(NUM_CAN)) u_sel (
      .sel     (sel_d[d]),
      .eth_evt (eth_d[d]),
      .can_evt (can_evt),
      .hit     (hit_d[d])
    );
    snap_pulse_stretch #(.PULSE_LEN(PULSE_LEN)) u_str (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (flush_d[d]),
      .trig  (hit_d[d]),
      .pulse (pulse_d[d])
    );
  end

  assign reg_rdata     = cfg_pack(cfg_q);
  assign rx_snap_pulse = pulse_d[0];
  assign tx_snap_pulse = pulse_d[1];
endmodule

// File: rtl/snap_test_mon_chk.sv
module snap_test_mon_chk #(
  parameter int NUM_ETH   = 5,
  parameter int NUM_CAN   = 2,
  parameter int PULSE_LEN = 8
) (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] rdata,
  input logic [1:0]  pulse,
  input logic [1:0]  hit,
  input logic [1:0]  flush
);
  localparam int AGE_W    = $clog2(PULSE_LEN + 2);
  localparam int CAN_BASE = 8;

  // R2
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata & ~32'h0000_0FF3) == 32'h0);

  // R6
  tm_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rdata[0] |-> pulse == 2'b00);

  for (genvar d = 0; d < 2; d++) begin : g_d
    logic [3:0]       code;
    logic [AGE_W-1:0] age;
    assign code = (d == 0) ? rdata[11:8] : rdata[7:4];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          age <= '0;
      else if (hit[d] && !flush[d])        age <= '0;
      else if (age != AGE_W'(PULSE_LEN+1)) age <= age + 1'b1;
    end

    // R5
    rsvd_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((code >= 4'(NUM_ETH) && code < 4'(CAN_BASE)) || code >= 4'(CAN_BASE + NUM_CAN))
        |-> !hit[d]);

    // R7
    pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pulse[d] |-> age < AGE_W'(PULSE_LEN));

    // R8
    retrig_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit[d] && !flush[d]) |=> pulse[d]);

    // R9
    flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush[d] |=> !pulse[d]);
  end
endmodule

bind snap_test_mon snap_test_mon_chk #(
  .NUM_ETH(NUM_ETH), .NUM_CAN(NUM_CAN), .PULSE_LEN(PULSE_LEN)
) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .rdata (reg_rdata),
  .pulse ({tx_snap_pulse, rx_snap_pulse}),
  .hit   (hit_d),
  .flush (flush_d)
);

// File: tb/tb_snap_test_mon.sv
module tb_snap_test_mon;
  localparam int NE = 5;
  localparam int NC = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [NE-1:0] eth_rx_evt = '0;
  logic [NE-1:0] eth_tx_evt = '0;
  logic [NC-1:0] can_evt = '0;
  logic        rx_snap_pulse, tx_snap_pulse;

  int checks = 0;
  int fails  = 0;
  string cur_tag = "R1";

  // reference state
  int unsigned m_reg = 0;
  int m_rx = 0;
  int m_tx = 0;

  always #2 clk = ~clk;

  snap_test_mon dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .eth_rx_evt(eth_rx_evt), .eth_tx_evt(eth_tx_evt),
    .can_evt(can_evt), .rx_snap_pulse(rx_snap_pulse), .tx_snap_pulse(tx_snap_pulse)
  );

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // which source a code names: R3 Ethernet 0..4, R4 CAN at 8/9, R5 nothing else
  function automatic bit src_fires(int code, logic [NE-1:0] eth, logic [NC-1:0] can);
    if (code < NE) return eth[code];
    if (code == 8) return can[0];
    if (code == 9) return can[1];
    return 1'b0;
  endfunction

  function automatic int next_len(int cur, bit drop, bit fire);
    if (drop) return 0;
    if (fire) return 8;
    return (cur > 0) ? cur - 1 : 0;
  endfunction

  task automatic tick();
    int unsigned nw;
    bit tm, drop_r, drop_t;
    int rsel, tsel;
    @(posedge clk);
    tm   = m_reg[0];
    rsel = (m_reg >> 8) & 15;
    tsel = (m_reg >> 4) & 15;
    nw   = reg_wdata & 32'h0000_0FF3;
    drop_r = !tm || (reg_wr_en && (!nw[0] || ((nw >> 8) & 15) != rsel));
    drop_t = !tm || (reg_wr_en && (!nw[0] || ((nw >> 4) & 15) != tsel));
    m_rx = next_len(m_rx, drop_r, src_fires(rsel, eth_rx_evt, can_evt));
    m_tx = next_len(m_tx, drop_t, src_fires(tsel, eth_tx_evt, can_evt));
    if (reg_wr_en) m_reg = nw;
    @(negedge clk);
    chk(cur_tag, "rdata", reg_rdata, m_reg);
    chk(cur_tag, "rx_pulse", {31'b0, rx_snap_pulse}, {31'b0, m_rx > 0});
    chk(cur_tag, "tx_pulse", {31'b0, tx_snap_pulse}, {31'b0, m_tx > 0});
    reg_wr_en  = 1'b0;
    eth_rx_evt = '0;
    eth_tx_evt = '0;
    can_evt    = '0;
  endtask

  task automatic wr(int unsigned v);
    reg_wr_en = 1'b1;
    reg_wdata = v;
    tick();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  // fire source s (0..NE-1 Ethernet, NE.. CAN) on both directions
  task automatic fire(int s);
    if (s < NE) begin
      eth_rx_evt[s] = 1'b1;
      eth_tx_evt[s] = 1'b1;
    end else begin
      can_evt[s-NE] = 1'b1;
    end
  endtask

  function automatic int unsigned cfg(int rx, int tx, bit aux, bit tm);
    return (rx << 8) | (tx << 4) | (aux << 1) | tm;
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int hi;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "rdata", reg_rdata, 32'h0);
    chk("R1", "rx_pulse", {31'b0, rx_snap_pulse}, 32'h0);
    chk("R1", "tx_pulse", {31'b0, tx_snap_pulse}, 32'h0);
    rst_n = 1'b1;
    idle(2);

    // R2: field storage, other bits read zero
    cur_tag = "R2";
    wr(32'hFFFF_FFFF);
    chk("R2", "rdata_all", reg_rdata, 32'h0000_0FF3);
    wr(32'hA5A5_A5A4);
    chk("R2", "rdata_pat", reg_rdata, 32'h0000_05A0);
    wr(0);

    // R6: test mode clear, all sources active
    cur_tag = "R6";
    for (int s = 0; s < NE + NC; s++) begin fire(s); idle(3); end
    wr(cfg(8, 9, 1'b0, 1'b0));
    for (int s = 0; s < NE + NC; s++) begin fire(s); idle(2); end

    // R10: auxiliary bit set without test mode still leaves outputs low
    cur_tag = "R10";
    wr(cfg(0, 0, 1'b1, 1'b0));
    fire(0);
    tick();
    chk("R10", "rx_aux_only", {31'b0, rx_snap_pulse}, 32'h0);
    idle(3);

    // R3 R4 R5 R7: every code against every source
    for (int c = 0; c < 16; c++) begin
      cur_tag = (c < NE) ? "R3" : ((c == 8 || c == 9) ? "R4" : "R5");
      wr(cfg(c, (c + 3) % 16, 1'b0, 1'b1));
      for (int s = 0; s < NE + NC; s++) begin
        fire(s);
        idle(10);
      end
    end

    // R7: explicit width of one pulse on Ethernet 2
    cur_tag = "R7";
    wr(cfg(2, 2, 1'b0, 1'b1));
    eth_rx_evt[2] = 1'b1;
    hi = 0;
    tick();
    for (int i = 0; i < 12; i++) begin
      if (rx_snap_pulse) hi++;
      tick();
    end
    chk("R7", "rx_high_cycles", hi, 8);

    // R8: retrigger mid-pulse extends the pulse
    cur_tag = "R8";
    eth_rx_evt[2] = 1'b1;
    idle(5);
    eth_rx_evt[2] = 1'b1;
    hi = 0;
    tick();
    for (int i = 0; i < 12; i++) begin
      if (rx_snap_pulse) hi++;
      tick();
    end
    chk("R8", "rx_high_after_retrig", hi, 8);

    // R9: clear test mode mid-pulse
    cur_tag = "R9";
    fire(2);
    idle(3);
    wr(cfg(2, 2, 1'b0, 1'b0));
    chk("R9", "rx_after_tm_clear", {31'b0, rx_snap_pulse}, 32'h0);
    // change rx select mid-pulse, tx select unchanged keeps going
    wr(cfg(2, 2, 1'b0, 1'b1));
    fire(2);
    idle(2);
    wr(cfg(3, 2, 1'b0, 1'b1));
    chk("R9", "rx_after_sel_change", {31'b0, rx_snap_pulse}, 32'h0);
    chk("R9", "tx_kept", {31'b0, tx_snap_pulse}, 32'h1);
    idle(8);
    // strobe in same edge as a select-changing write is dropped
    fire(3);
    wr(cfg(4, 2, 1'b0, 1'b1));
    chk("R9", "rx_same_edge_drop", {31'b0, rx_snap_pulse}, 32'h0);
    idle(3);

    // R10: toggling the auxiliary bit mid-pulse has no effect
    cur_tag = "R10";
    fire(4);
    idle(2);
    wr(cfg(4, 2, 1'b1, 1'b1));
    chk("R10", "rx_aux_toggle", {31'b0, rx_snap_pulse}, 32'h1);
    idle(10);

    // R11: enabling write and strobe on the same edge: strobe ignored
    cur_tag = "R11";
    wr(cfg(1, 1, 1'b0, 1'b0));
    fire(1);
    wr(cfg(1, 1, 1'b0, 1'b1));
    chk("R11", "rx_same_edge_enable", {31'b0, rx_snap_pulse}, 32'h0);
    fire(1);
    tick();
    chk("R11", "rx_next_edge", {31'b0, rx_snap_pulse}, 32'h1);
    idle(10);

    // random mixture, compared every cycle
    cur_tag = "R7";
    for (int i = 0; i < 3000; i++) begin
      eth_rx_evt = NE'($urandom) & NE'($urandom);
      eth_tx_evt = NE'($urandom) & NE'($urandom);
      can_evt    = NC'($urandom) & NC'($urandom);
      if (($urandom % 16) == 0) begin
        reg_wr_en = 1'b1;
        reg_wdata = $urandom;
        if (($urandom % 4) != 0) reg_wdata[0] = 1'b1;
      end
      tick();
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule